// File: doc/BRIEF.md
# SMM Memory Window Access Controller

This block holds one 8-bit control register that decides when the protected system-management memory window at A0000h–BFFFFh (128 KB) is backed by local DRAM. It also holds the decoder that steers each memory access to that DRAM or to the downstream bus. Software reaches the register through a small configuration port made of an address, a write enable, write data and read data. The register answers only at offset 90h.

Each access presents an address, a flag that marks system-management mode and a flag that separates code fetches from data references. One cycle after the access strobe the block reports a registered route. An in-window access goes to DRAM when the visibility rules hold and to the downstream bus when they do not. An address outside the window is claimed by neither path. No address is ever remapped.

A sticky lock bit protects the window once firmware has set it up. Setting the lock clears the open control and freezes the open, lock and enable bits until a full reset. The lock is exported as a freeze signal so that neighbouring memory-map registers become read-only at the same time.

Top module: `smm_win_ctrl`

## Requirements
- R1: The register is decoded at configuration offset 90h and reads 02h after reset. Reads at any other offset return 00h, and writes there change nothing.
- R2: Bit 7 always reads 0. Bits 2:0 always read 010 whatever is written.
- R3: While the enable (bit 3) is 0, no access goes to DRAM, and every in-window access goes downstream, whatever the open, closed and lock bits hold.
- R4: With enable=1, open (bit 6)=1 and lock (bit 4)=0, an in-window access made outside SMM mode goes to DRAM, even when closed (bit 5) is 1.
- R5: With enable=1, an in-window SMM-mode code fetch goes to DRAM. An in-window SMM-mode data access goes to DRAM only when closed=0, and goes downstream otherwise.
- R6: An access outside A0000h–BFFFFh raises neither the DRAM nor the downstream route output. Both route outputs are never high together.
- R7: Writing 1 to lock sets it. While lock=1, open reads 0, and writes to open, lock and enable have no effect. Only reset clears lock.
- R8: The closed bit stays writable after lock. A single write that sets both lock and open leaves open at 0.
- R9: The freeze output equals the lock bit.
- R10: Route outputs are registered. The route valid output is high in the cycle after the clock edge that samples an access strobe, and low after an edge that samples no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low full reset |
| cfg_addr | input | 8 | Configuration offset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | 32 | Access address |
| acc_smm | input | 1 | Access made in SMM mode |
| acc_code | input | 1 | Access is a code fetch (0 = data) |
| rt_valid | output | 1 | Registered route valid |
| rt_dram | output | 1 | Access routed to window DRAM |
| rt_down | output | 1 | In-window access routed to downstream bus |
| map_freeze | output | 1 | Freeze for other memory-map registers |

## Verification
The bench sweeps every mix of enable, open, closed and lock written in one cycle, with SMM and code flags, against a reference table. A decoder that let closed override open outside SMM mode, or that kept open set when lock arrives in the same write, would route wrongly there. Directed tests try to clear lock, reopen the window and drop the enable after locking. A lock that is not sticky would show in the readback and in the next route. Window edge addresses 9FFFFh, A0000h, BFFFFh and C0000h catch off-by-one bounds, which would claim a neighbour's access or drop the window's last byte.

// File: rtl/smm_win_pkg.sv
// Shared types and constants for the SMM window controller.
// Assumes an 8-bit configuration data path with fixed bit positions.
package smm_win_pkg;
    typedef struct packed {
        logic open;
        logic closed;
        logic lock;
        logic gen;
    } smm_ctl_t;

    localparam logic [2:0] BASE_SEG_CODE = 3'b010;
    localparam int         CFG_DW        = 8;
    localparam int         BIT_OPEN      = 6;
    localparam int         BIT_CLOSED    = 5;
    localparam int         BIT_LOCK      = 4;
    localparam int         BIT_GEN       = 3;
endpackage

// File: rtl/smm_ctl_reg.sv
// Control register for the SMM window.
// Holds open/closed/lock/enable and applies the sticky-lock write rules.
// Assumes writes take effect at the clock edge that samples cfg_we.
module smm_ctl_reg
    import smm_win_pkg::*;
#(
    parameter int                CFG_AW     = 8,
    parameter logic [CFG_AW-1:0] CFG_OFFSET = 8'h90
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic              cfg_we,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic [CFG_DW-1:0] cfg_rdata,
    output smm_ctl_t          ctl
);
    smm_ctl_t ctl_q;
    logic     hit;

    assign hit = (cfg_addr == CFG_OFFSET);
    assign ctl = ctl_q;

    // Register update: closed always writable, the rest frozen by lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (cfg_we && hit) begin
            ctl_q.closed <= cfg_wdata[BIT_CLOSED];
            if (!ctl_q.lock) begin
                ctl_q.gen  <= cfg_wdata[BIT_GEN];
                ctl_q.lock <= cfg_wdata[BIT_LOCK];
                ctl_q.open <= cfg_wdata[BIT_OPEN] & ~cfg_wdata[BIT_LOCK];
            end
        end
    end

    // Read mux: field image at the decoded offset, zero elsewhere.
    always_comb begin
        if (hit) cfg_rdata = {1'b0, ctl_q.open, ctl_q.closed, ctl_q.lock, ctl_q.gen, BASE_SEG_CODE};
        else     cfg_rdata = '0;
    end

    assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.lock |=> ctl_q.lock);
    assert_open_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.lock |-> !ctl_q.open);
    assert_gen_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.lock |=> $stable(ctl_q.gen));
endmodule

// File: rtl/smm_win_decode.sv
// Combinational window decoder.
// Classifies an access as window DRAM, downstream, or unclaimed.
// Assumes the window is one contiguous range [WIN_BASE, WIN_BASE+WIN_SIZE).
module smm_win_decode
    import smm_win_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h000A_0000,
    parameter logic [ADDR_W-1:0] WIN_SIZE = 32'h0002_0000
) (
    input  smm_ctl_t          ctl,
    input  logic [ADDR_W-1:0] addr,
    input  logic              smm,
    input  logic              code,
    output logic              to_dram,
    output logic              to_down
);
    localparam logic [ADDR_W-1:0] WIN_LAST = WIN_BASE + WIN_SIZE - 1'b1;

    logic in_win;
    logic visible;

    // Window hit and visibility: SMM uses closed/code, others use open.
    always_comb begin
        in_win  = (addr >= WIN_BASE) && (addr <= WIN_LAST);
        visible = ctl.gen && (smm ? (code || !ctl.closed) : (ctl.open && !ctl.lock));
        to_dram = in_win && visible;
        to_down = in_win && !visible;
    end
endmodule

// File: rtl/smm_win_ctrl.sv
// Top of the SMM window controller: register, decoder and route register.
// Route outputs appear one cycle after the access strobe; map_freeze
// mirrors the lock bit for neighbouring memory-map registers.
module smm_win_ctrl
    import smm_win_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                CFG_AW     = 8,
    parameter logic [CFG_AW-1:0] CFG_OFFSET = 8'h90,
    parameter logic [ADDR_W-1:0] WIN_BASE   = 32'h000A_0000,
    parameter logic [ADDR_W-1:0] WIN_SIZE   = 32'h0002_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_smm,
    input  logic              acc_code,
    output logic              rt_valid,
    output logic              rt_dram,
    output logic              rt_down,
    output logic              map_freeze
);
    smm_ctl_t ctl;
    logic     dec_dram;
    logic     dec_down;

    smm_ctl_reg #(.CFG_AW(CFG_AW), .CFG_OFFSET(CFG_OFFSET)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_addr  (cfg_addr),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .ctl       (ctl)
    );

    smm_win_decode #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE)) u_dec (
        .ctl     (ctl),
        .addr    (acc_addr),
        .smm     (acc_smm),
        .code    (acc_code),
        .to_dram (dec_dram),
        .to_down (dec_down)
    );

    assign map_freeze = ctl.lock;

    // Route register: capture the decode on each strobe, clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rt_valid <= 1'b0;
            rt_dram  <= 1'b0;
            rt_down  <= 1'b0;
        end else begin
            rt_valid <= acc_valid;
            rt_dram  <= acc_valid & dec_dram;
            rt_down  <= acc_valid & dec_down;
        end
    end

    assert_route_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rt_dram && rt_down));
    assert_strobe_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> rt_valid);
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !(rt_valid || rt_dram || rt_down));
    assert_dram_needs_gen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !ctl.gen) |=> !rt_dram);
endmodule

// File: tb/test_smm_win_ctrl.sv
// Self-checking bench: address vector table, exhaustive control sweep,
// then directed reset, reserved-field and lock tests.
module test_smm_win_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  cfg_addr;
    logic        cfg_we;
    logic [7:0]  cfg_wdata;
    logic [7:0]  cfg_rdata;
    logic        acc_valid;
    logic [31:0] acc_addr;
    logic        acc_smm;
    logic        acc_code;
    logic        rt_valid, rt_dram, rt_down, map_freeze;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    smm_win_ctrl i_smm_win_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cfg_addr(cfg_addr), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_smm(acc_smm), .acc_code(acc_code),
        .rt_valid(rt_valid), .rt_dram(rt_dram), .rt_down(rt_down), .map_freeze(map_freeze)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic        smm;
        logic        code;
        logic        dram;
        logic        down;
    } vec_t;

    // Config for the table: enable=1, closed=1, open=0, lock=0.
    localparam vec_t VECS [8] = '{
        '{32'h000A_0000, 1'b1, 1'b0, 1'b0, 1'b1},
        '{32'h000A_0000, 1'b1, 1'b1, 1'b1, 1'b0},
        '{32'h000B_FFFF, 1'b1, 1'b1, 1'b1, 1'b0},
        '{32'h0009_FFFF, 1'b1, 1'b1, 1'b0, 1'b0},
        '{32'h000C_0000, 1'b1, 1'b1, 1'b0, 1'b0},
        '{32'h000A_FFFF, 1'b0, 1'b1, 1'b0, 1'b1},
        '{32'h0000_0000, 1'b1, 1'b1, 1'b0, 1'b0},
        '{32'h000B_1234, 1'b1, 1'b0, 1'b0, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cfg_we = 1'b0; acc_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
        cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; cfg_addr = 8'h90;
    endtask

    task automatic cfg_read(input logic [7:0] a, input string req, input logic [7:0] exp);
        cfg_addr = a;
        #1;
        check(req, {24'h0, cfg_rdata}, {24'h0, exp});
        cfg_addr = 8'h90;
    endtask

    task automatic access(input logic [31:0] a, input logic s, input logic c,
                          input string req, input logic ed, input logic ew);
        acc_addr = a; acc_smm = s; acc_code = c; acc_valid = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0;
        check({req, " route"}, {29'h0, rt_valid, rt_dram, rt_down}, {29'h0, 1'b1, ed, ew});
        @(negedge clk);
        check("R10 idle", {31'h0, rt_valid}, 32'h0);
    endtask

    function automatic logic ref_dram(input logic g, input logic o, input logic cl,
                                      input logic lk, input logic s, input logic c);
        logic o_eff;
        o_eff = o & ~lk;
        return g & (s ? (c | ~cl) : o_eff);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_addr = 8'h90; cfg_we = 1'b0; cfg_wdata = '0;
        acc_valid = 1'b0; acc_addr = '0; acc_smm = 1'b0; acc_code = 1'b0;
        do_reset();

        // R1: reset value and freeze low
        cfg_read(8'h90, "R1 reset", 8'h02);
        check("R9 freeze reset", {31'h0, map_freeze}, 32'h0);
        check("R10 reset route", {29'h0, rt_valid, rt_dram, rt_down}, 32'h0);

        // Table walk: enable=1 closed=1 (R5, R6)
        cfg_write(8'h90, 8'h28);
        for (int i = 0; i < 8; i++)
            access(VECS[i].addr, VECS[i].smm, VECS[i].code, "R5/R6 table", VECS[i].dram, VECS[i].down);

        // Exhaustive control sweep (R3, R4, R5, R8)
        for (int k = 0; k < 64; k++) begin
            logic g, o, cl, lk, s, c, ed;
            {g, o, cl, lk, s, c} = k[5:0];
            do_reset();
            cfg_write(8'h90, {1'b0, o, cl, lk, g, 3'b000});
            cfg_read(8'h90, "R8 sweep readback", {1'b0, o & ~lk, cl, lk, g, 3'b010});
            ed = ref_dram(g, o, cl, lk, s, c);
            access(32'h000A_8000, s, c, g ? "R4/R5 sweep" : "R3 sweep", ed, ~ed);
        end

        // R1: other offsets
        do_reset();
        cfg_write(8'h91, 8'hFF);
        cfg_read(8'h90, "R1 other offset write", 8'h02);
        cfg_read(8'h91, "R1 other offset read", 8'h00);

        // R2: reserved and base field
        cfg_write(8'h90, 8'hA7);
        cfg_read(8'h90, "R2 fixed fields", 8'h22);

        // R7/R8/R9: lock behaviour
        do_reset();
        cfg_write(8'h90, 8'h48);
        cfg_read(8'h90, "R4 open set", 8'h4A);
        access(32'h000B_0000, 1'b0, 1'b0, "R4 open non-SMM", 1'b1, 1'b0);
        cfg_write(8'h90, 8'h58);
        cfg_read(8'h90, "R8 lock with open", 8'h1A);
        check("R9 freeze set", {31'h0, map_freeze}, 32'h1);
        cfg_write(8'h90, 8'h20);
        cfg_read(8'h90, "R7 lock ignores clear, R8 closed writable", 8'h3A);
        cfg_write(8'h90, 8'h40);
        cfg_read(8'h90, "R7 open ignored after lock", 8'h1A);
        access(32'h000B_0000, 1'b0, 1'b0, "R7 no reopen", 1'b0, 1'b1);
        access(32'h000B_0000, 1'b1, 1'b0, "R7 SMM data locked", 1'b1, 1'b0);
        do_reset();
        cfg_read(8'h90, "R7 reset clears lock", 8'h02);
        check("R9 freeze cleared", {31'h0, map_freeze}, 32'h0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule